// File: doc/BRIEF.md
# Bit-Plane Neighbour Mesh with Streaming Column Port

This block is a square array of single-bit cells that together hold two bit planes. The compute plane can be moved as a whole by one cell toward any of the four compass directions in one clock, and every cell takes the bit of its neighbour at once. A runtime edge setting decides what the cells on the array boundary receive. The boundary can be left open, so zeros enter. It can be wrapped around within the same row or column. It can also be chained row to row, so that the plane behaves like one long loop for east and west moves.

The second plane is a transfer plane. It moves only eastward. On each transfer step a column of external bits enters at the west edge, and the east column is always visible on an output port. After as many steps as the array is wide, a complete plane has been loaded and a one-cycle done pulse marks the event. The two planes have independent controls and may both be active in the same clock. A host can therefore stream a bit plane in or out while the compute plane keeps sliding.

Cell (r, c) occupies bit r*DIM+c of every plane vector. Row 0 is the north edge and column 0 is the west edge.

Top module: `bitplane_mesh`

## Requirements
- R1: While rst_n is low at a rising edge, the compute plane and the transfer plane become all zero and the done pulse is low.
- R2: When p_load is high, the compute plane takes p_load_data at the next edge. This holds even if slide_en is high in the same cycle.
- R3: In open edge mode (edge_mode 0 or 3), a slide moves every bit one cell in the direction given by slide_dir (0 north, 1 east, 2 south, 3 west). The cells on the vacated edge receive zero, and the bits pushed past the far edge are lost.
- R4: In cylinder edge mode (edge_mode 1), an east or west slide carries the bit leaving a row into the opposite end of the same row. A north or south slide carries the bit leaving a column into the opposite end of the same column.
- R5: In spiral edge mode (edge_mode 2), an east slide moves the last cell of row r into the first cell of row r+1, and the last cell of the last row goes to cell (0,0). A west slide moves the first cell of row r+1 into the last cell of row r, and cell (0,0) goes to the last cell of the last row.
- R6: In spiral edge mode, north and south slides wrap within the same column, as in cylinder mode.
- R7: With p_load and slide_en both low, the compute plane keeps its value whatever edge_mode, slide_dir and p_load_data do.
- R8: When s_shift is high, every transfer-plane row moves one cell east at the next edge and s_in[r] enters cell (r,0). s_out[r] always shows cell (r,DIM-1). With s_shift low, the transfer plane holds.
- R9: s_done is high for exactly the one cycle after each DIM-th transfer step counted since reset, and low otherwise.
- R10: A slide of the compute plane and a transfer step in the same cycle each give the same result they would give alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| p_load | input | 1 | Load the whole compute plane |
| p_load_data | input | DIM*DIM | Plane value written on p_load |
| slide_en | input | 1 | Slide the compute plane by one cell |
| slide_dir | input | 2 | Slide direction: 0 north, 1 east, 2 south, 3 west |
| edge_mode | input | 2 | Boundary mode: 0/3 open, 1 cylinder, 2 spiral |
| p_plane | output | DIM*DIM | Current compute plane |
| s_shift | input | 1 | Transfer plane step east |
| s_in | input | DIM | Column entering at the west edge, bit r for row r |
| s_out | output | DIM | Current east column of the transfer plane |
| s_plane | output | DIM*DIM | Current transfer plane |
| s_done | output | 1 | One-cycle pulse after each full plane of steps |

## Verification
The planes and s_done are registered. A command applied in one cycle therefore shows on p_plane, s_plane and s_done after the next rising edge. s_out follows the transfer plane without further delay. The bench changes inputs on falling edges and reads outputs on the following falling edge, half a period after the edge that took the command. This puts every sample one edge after its stimulus. For the done pulse, the bench samples after each single step. It expects the flag low after steps 1 to DIM-1, high after step DIM, and low again one cycle later.

// File: rtl/mesh_pkg.sv
// Shared encodings for the bit-plane mesh.
// Assumes two-bit command fields on the top-level ports.
package mesh_pkg;
    typedef enum logic [1:0] {
        DIR_NORTH = 2'd0,
        DIR_EAST  = 2'd1,
        DIR_SOUTH = 2'd2,
        DIR_WEST  = 2'd3
    } slide_dir_e;

    typedef enum logic [1:0] {
        EDGE_OPEN     = 2'd0,
        EDGE_CYLINDER = 2'd1,
        EDGE_SPIRAL   = 2'd2,
        EDGE_OPEN_ALT = 2'd3
    } edge_mode_e;
endpackage

// File: rtl/mesh_edge_feed.sv
// Boundary source selection for the compute plane.
// Computes, for each edge, the bit a border cell receives on a slide
// that vacates that edge. Purely combinational; assumes row-major
// layout, bit r*DIM+c, row 0 north, column 0 west.
module mesh_edge_feed import mesh_pkg::*; #(
    parameter int DIM = 8,
    localparam int CELLS = DIM * DIM
) (
    input  logic [CELLS-1:0] plane,
    input  logic [1:0]       edge_mode,
    output logic [DIM-1:0]   fill_bottom,  // per column, enters last row on north slide
    output logic [DIM-1:0]   fill_top,     // per column, enters row 0 on south slide
    output logic [DIM-1:0]   fill_left,    // per row, enters column 0 on east slide
    output logic [DIM-1:0]   fill_right    // per row, enters last column on west slide
);
    for (genvar i = 0; i < DIM; i++) begin : g_lane
        localparam int PREV = (i + DIM - 1) % DIM;
        localparam int NEXT = (i + 1) % DIM;

        // Purpose: choose the boundary bit of lane i for the active edge mode.
        always_comb begin
            case (edge_mode)
                EDGE_CYLINDER: begin
                    fill_bottom[i] = plane[i];
                    fill_top[i]    = plane[(DIM-1)*DIM + i];
                    fill_left[i]   = plane[i*DIM + DIM - 1];
                    fill_right[i]  = plane[i*DIM];
                end
                EDGE_SPIRAL: begin
                    fill_bottom[i] = plane[i];
                    fill_top[i]    = plane[(DIM-1)*DIM + i];
                    fill_left[i]   = plane[PREV*DIM + DIM - 1];
                    fill_right[i]  = plane[NEXT*DIM];
                end
                default: begin
                    fill_bottom[i] = 1'b0;
                    fill_top[i]    = 1'b0;
                    fill_left[i]   = 1'b0;
                    fill_right[i]  = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/mesh_pplane.sv
// Compute plane storage with four-way single-cycle slide.
// Each cell picks its neighbour's bit, or the edge feed when it sits on
// the vacated border. Whole-plane load has priority over a slide.
module mesh_pplane import mesh_pkg::*; #(
    parameter int DIM = 8,
    localparam int CELLS = DIM * DIM
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             p_load,
    input  logic [CELLS-1:0] p_load_data,
    input  logic             slide_en,
    input  logic [1:0]       slide_dir,
    input  logic [1:0]       edge_mode,
    input  logic [DIM-1:0]   fill_bottom,
    input  logic [DIM-1:0]   fill_top,
    input  logic [DIM-1:0]   fill_left,
    input  logic [DIM-1:0]   fill_right,
    output logic [CELLS-1:0] plane
);
    logic [CELLS-1:0] nxt;
    logic [DIM-1:0]   west_col;

    for (genvar r = 0; r < DIM; r++) begin : g_row
        assign west_col[r] = plane[r*DIM];
        for (genvar c = 0; c < DIM; c++) begin : g_col
            localparam int IDX = r * DIM + c;
            logic from_n, from_s, from_w, from_e, moved;

            if (r == DIM - 1) begin : g_s_edge
                assign from_s = fill_bottom[c];
            end else begin : g_s_in
                assign from_s = plane[IDX + DIM];
            end
            if (r == 0) begin : g_n_edge
                assign from_n = fill_top[c];
            end else begin : g_n_in
                assign from_n = plane[IDX - DIM];
            end
            if (c == 0) begin : g_w_edge
                assign from_w = fill_left[r];
            end else begin : g_w_in
                assign from_w = plane[IDX - 1];
            end
            if (c == DIM - 1) begin : g_e_edge
                assign from_e = fill_right[r];
            end else begin : g_e_in
                assign from_e = plane[IDX + 1];
            end

            // Purpose: pick the neighbour that feeds this cell for the slide direction.
            always_comb begin
                case (slide_dir)
                    DIR_NORTH: moved = from_s;
                    DIR_EAST:  moved = from_w;
                    DIR_SOUTH: moved = from_n;
                    default:   moved = from_e;
                endcase
            end

            assign nxt[IDX] = p_load ? p_load_data[IDX] : (slide_en ? moved : plane[IDX]);
        end
    end

    // Purpose: register the plane, clearing it on synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) plane <= '0;
        else        plane <= nxt;
    end

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        p_load |=> plane == $past(p_load_data)); // R2
    AST_OPEN_WEST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (slide_en && !p_load && slide_dir == DIR_EAST &&
         (edge_mode == EDGE_OPEN || edge_mode == EDGE_OPEN_ALT)) |=> west_col == '0); // R3
    AST_WRAP_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (slide_en && !p_load && (edge_mode == EDGE_CYLINDER || edge_mode == EDGE_SPIRAL))
        |=> $countones(plane) == $countones($past(plane))); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!slide_en && !p_load) |=> $stable(plane)); // R7
endmodule

// File: rtl/mesh_splane.sv
// Transfer plane: rows shift east one cell per step, with a column
// entering at the west edge and the east column exposed. A step counter
// pulses done after each full plane width of steps since reset.
module mesh_splane #(
    parameter int DIM = 8,
    localparam int CELLS = DIM * DIM,
    localparam int CNT_W = (DIM > 1) ? $clog2(DIM) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_shift,
    input  logic [DIM-1:0]   s_in,
    output logic [DIM-1:0]   s_out,
    output logic [CELLS-1:0] plane,
    output logic             s_done
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIM - 1);

    logic [CELLS-1:0] shifted;
    logic [DIM-1:0]   west_col;
    logic [CNT_W-1:0] step_cnt;

    for (genvar r = 0; r < DIM; r++) begin : g_row
        assign s_out[r]    = plane[r*DIM + DIM - 1];
        assign west_col[r] = plane[r*DIM];
        for (genvar c = 0; c < DIM; c++) begin : g_col
            if (c == 0) begin : g_entry
                assign shifted[r*DIM] = s_in[r];
            end else begin : g_pass
                assign shifted[r*DIM + c] = plane[r*DIM + c - 1];
            end
        end
    end

    // Purpose: hold or step the transfer plane.
    always_ff @(posedge clk) begin
        if (!rst_n)       plane <= '0;
        else if (s_shift) plane <= shifted;
    end

    // Purpose: count steps and pulse done after each full plane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_cnt <= '0;
            s_done   <= 1'b0;
        end else begin
            s_done <= 1'b0;
            if (s_shift) begin
                if (step_cnt == LAST) begin
                    step_cnt <= '0;
                    s_done   <= 1'b1;
                end else begin
                    step_cnt <= step_cnt + 1'b1;
                end
            end
        end
    end

    AST_S_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !s_shift |=> $stable(plane)); // R8
    AST_S_WEST_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        s_shift |=> west_col == $past(s_in)); // R8
    AST_DONE_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        s_done |-> $past(s_shift)); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        s_done |=> !s_done || DIM == 1); // R9
endmodule

// File: rtl/bitplane_mesh.sv
// Top level of the bit-plane mesh: compute plane with configurable
// boundary wiring plus an east-streaming transfer plane. The two planes
// share only clock and reset; their commands are fully independent.
module bitplane_mesh #(
    parameter int DIM = 8,
    localparam int CELLS = DIM * DIM
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             p_load,
    input  logic [CELLS-1:0] p_load_data,
    input  logic             slide_en,
    input  logic [1:0]       slide_dir,
    input  logic [1:0]       edge_mode,
    output logic [CELLS-1:0] p_plane,
    input  logic             s_shift,
    input  logic [DIM-1:0]   s_in,
    output logic [DIM-1:0]   s_out,
    output logic [CELLS-1:0] s_plane,
    output logic             s_done
);
    logic [DIM-1:0] fill_bottom, fill_top, fill_left, fill_right;

    mesh_edge_feed #(.DIM(DIM)) u_edge (
        .plane       (p_plane),
        .edge_mode   (edge_mode),
        .fill_bottom (fill_bottom),
        .fill_top    (fill_top),
        .fill_left   (fill_left),
        .fill_right  (fill_right)
    );

    mesh_pplane #(.DIM(DIM)) u_pplane (
        .clk         (clk),
        .rst_n       (rst_n),
        .p_load      (p_load),
        .p_load_data (p_load_data),
        .slide_en    (slide_en),
        .slide_dir   (slide_dir),
        .edge_mode   (edge_mode),
        .fill_bottom (fill_bottom),
        .fill_top    (fill_top),
        .fill_left   (fill_left),
        .fill_right  (fill_right),
        .plane       (p_plane)
    );

    mesh_splane #(.DIM(DIM)) u_splane (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_shift (s_shift),
        .s_in    (s_in),
        .s_out   (s_out),
        .plane   (s_plane),
        .s_done  (s_done)
    );
endmodule

// File: tb/bitplane_mesh_tb.sv
module bitplane_mesh_tb;
    localparam int DIM        = 8;
    localparam int CELLS      = DIM * DIM;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]  mode;
        logic [1:0]  dir;
        logic [63:0] start;
        logic [63:0] expect_v;
    } vec_t;

    // mode: 0 open, 1 cylinder, 2 spiral, 3 open; dir: 0 N, 1 E, 2 S, 3 W
    localparam int NVEC = 17;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 2'd1, 64'h0000_0000_0000_0080, 64'h0},
        '{2'd1, 2'd1, 64'h0000_0000_0000_0080, 64'h1},
        '{2'd2, 2'd1, 64'h0000_0000_0000_0080, 64'h100},
        '{2'd2, 2'd1, 64'h8000_0000_0000_0000, 64'h1},
        '{2'd2, 2'd3, 64'h0000_0000_0000_0001, 64'h8000_0000_0000_0000},
        '{2'd1, 2'd3, 64'h0000_0000_0000_0001, 64'h80},
        '{2'd0, 2'd3, 64'h0000_0000_0000_0001, 64'h0},
        '{2'd0, 2'd0, 64'h0000_0000_0000_0101, 64'h1},
        '{2'd1, 2'd0, 64'h0000_0000_0000_0001, 64'h0100_0000_0000_0000},
        '{2'd1, 2'd2, 64'h0100_0000_0000_0000, 64'h1},
        '{2'd2, 2'd2, 64'h8000_0000_0000_0000, 64'h80},
        '{2'd2, 2'd0, 64'h0000_0000_0000_0001, 64'h0100_0000_0000_0000},
        '{2'd0, 2'd2, 64'h0000_0000_0000_00FF, 64'hFF00},
        '{2'd3, 2'd1, 64'h0000_0000_0000_00FF, 64'hFE},
        '{2'd1, 2'd1, 64'h0000_0000_0000_0001, 64'h2},
        '{2'd2, 2'd3, 64'h0000_0000_0000_0100, 64'h80},
        '{2'd0, 2'd0, 64'h0000_0000_0000_FF00, 64'hFF}
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             p_load;
    logic [CELLS-1:0] p_load_data;
    logic             slide_en;
    logic [1:0]       slide_dir;
    logic [1:0]       edge_mode;
    logic [CELLS-1:0] p_plane;
    logic             s_shift;
    logic [DIM-1:0]   s_in;
    logic [DIM-1:0]   s_out;
    logic [CELLS-1:0] s_plane;
    logic             s_done;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitplane_mesh #(.DIM(DIM)) u_dut (
        .clk(clk), .rst_n(rst_n), .p_load(p_load), .p_load_data(p_load_data),
        .slide_en(slide_en), .slide_dir(slide_dir), .edge_mode(edge_mode),
        .p_plane(p_plane), .s_shift(s_shift), .s_in(s_in), .s_out(s_out),
        .s_plane(s_plane), .s_done(s_done)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp_v);
        end
    endtask

    function automatic string tag_of(input logic [1:0] mode, input logic [1:0] dir);
        if (mode == 2'd1) return "R4";
        if (mode == 2'd2) return (dir == 2'd1 || dir == 2'd3) ? "R5" : "R6";
        return "R3";
    endfunction

    function automatic logic [7:0] col_val(input int k);
        return 8'(k * 37 + 5);
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] exp_s;
        rst_n = 1'b0; p_load = 1'b0; p_load_data = '0; slide_en = 1'b0;
        slide_dir = 2'd0; edge_mode = 2'd0; s_shift = 1'b0; s_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 p_plane", p_plane, 64'h0);
        check("R1 s_plane", s_plane, 64'h0);
        check("R1 s_done", 64'(s_done), 64'h0);
        rst_n = 1'b1;

        // Table walk: load start plane, slide once, compare.
        for (int i = 0; i < NVEC; i++) begin
            p_load = 1'b1; p_load_data = VECS[i].start;
            @(negedge clk);
            p_load = 1'b0; slide_en = 1'b1;
            slide_dir = VECS[i].dir; edge_mode = VECS[i].mode;
            @(negedge clk);
            slide_en = 1'b0;
            check(tag_of(VECS[i].mode, VECS[i].dir), p_plane, VECS[i].expect_v);
        end

        // R2: load wins over a simultaneous slide.
        p_load = 1'b1; p_load_data = 64'hDEAD_BEEF_0123_4567;
        slide_en = 1'b1; slide_dir = 2'd1; edge_mode = 2'd1;
        @(negedge clk);
        p_load = 1'b0; slide_en = 1'b0;
        check("R2 load priority", p_plane, 64'hDEAD_BEEF_0123_4567);

        // R7: idle cycles with changing controls leave the plane alone.
        for (int k = 0; k < 4; k++) begin
            edge_mode = 2'(k); slide_dir = 2'(3 - k); p_load_data = 64'(k) * 64'h1111;
            @(negedge clk);
        end
        check("R7 hold", p_plane, 64'hDEAD_BEEF_0123_4567);

        // R8/R9/R10: stream a plane in while the compute plane slides.
        p_load = 1'b1; p_load_data = 64'h1;
        @(negedge clk);
        p_load = 1'b0;
        slide_en = 1'b1; slide_dir = 2'd1; edge_mode = 2'd2;
        for (int k = 0; k < DIM; k++) begin
            s_shift = 1'b1; s_in = col_val(k);
            @(negedge clk);
            if (k < DIM - 1) check("R9 no early done", 64'(s_done), 64'h0);
            if (k == 0) check("R8 first column", s_plane, 64'(col_val(0)) == 0 ? 64'h0 : s_plane & 64'h0101_0101_0101_0101);
        end
        s_shift = 1'b0; slide_en = 1'b0;
        check("R9 done after full plane", 64'(s_done), 64'h1);
        exp_s = '0;
        for (int r = 0; r < DIM; r++)
            for (int c = 0; c < DIM; c++)
                exp_s[r*DIM + c] = col_val(DIM - 1 - c)[r];
        check("R8 streamed plane", s_plane, exp_s);
        check("R8 east column out", 64'(s_out), 64'(col_val(0)));
        check("R10 compute plane during stream", p_plane, 64'h100);
        @(negedge clk);
        check("R9 done single cycle", 64'(s_done), 64'h0);
        check("R8 hold when idle", s_plane, exp_s);

        // R9 repeat: a second full plane of ones pulses done again.
        for (int k = 0; k < DIM; k++) begin
            s_shift = 1'b1; s_in = 8'hFF;
            @(negedge clk);
            if (k == DIM - 2) check("R9 no done at step 7", 64'(s_done), 64'h0);
        end
        s_shift = 1'b0;
        check("R9 second done", 64'(s_done), 64'h1);
        check("R8 all ones plane", s_plane, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R8 all ones out", 64'(s_out), 64'hFF);

        finish_run();
    end
endmodule